// File: doc/BRIEF.md
# Dual-Mode Host Processor Bus Slave

This block lets an 8-bit host processor reach a small file of byte registers. The host presents a 9-bit address and exchanges data over a bidirectional byte lane. At the block boundary that lane is split into an input, an output and an output enable, and the chip pad logic forms the tri-state buffer from them. A static strap picks the strobe semantics. With the strap low, the host uses separate active-low read and write strobes. With the strap high, the host uses a single active-low data strobe plus a read/not-write direction line.

The address can arrive on its own pins, with the latch-enable input held high. It can also be multiplexed, in which case the block keeps the address present at the falling edge of the latch-enable input. Every host control line is brought into the system clock domain through a synchroniser. The address and data lines are delayed by the same number of stages, so the block samples them in step with the strobes. A write is committed exactly once, on the synchronised rising edge of the strobe that ends it.

Top module: `hostbus_slave`

## Requirements
- R1: While `rst` is high and immediately after it falls, `data_oe` is low, and every register afterwards reads back as 0x00.
- R2: With `mode_moto` = 0, holding `cs_n` and `rd_strb_n` low drives `data_oe` high within 3 clocks, and `data_out` then carries the addressed register.
- R3: With `mode_moto` = 0, each rising edge of `wr_rw_n` while `cs_n` is low stores `data_in` into the addressed register once.
- R4: With `mode_moto` = 1, holding `cs_n` and `rd_strb_n` low with `wr_rw_n` high drives `data_oe` high within 3 clocks, and `data_out` then carries the addressed register.
- R5: With `mode_moto` = 1, a rising edge of `rd_strb_n` while `cs_n` is low and `wr_rw_n` is low stores `data_in`. A strobe with `wr_rw_n` high never changes any register.
- R6: When `ale` pulses high and then falls, the address present at the fall is used for the following access, even if `addr` changes afterwards.
- R7: With `ale` held high, `addr` is used directly as the access address.
- R8: `data_oe` is low whenever `cs_n` has been high for 3 clocks, and it stays low throughout write cycles in either mode.
- R9: Strobes issued while `cs_n` is high leave every register unchanged.
- R10: For addresses at or above `NUM_REGS` (32 by default), reads return 0x00 with `data_oe` high, and writes are dropped without touching any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Active-high synchronous reset |
| mode_moto | input | 1 | Strap: 0 selects separate read/write strobes, 1 selects strobe plus direction line |
| cs_n | input | 1 | Active-low chip select |
| ale | input | 1 | Address latch enable; held high for non-multiplexed address |
| addr | input | 9 | Host address |
| rd_strb_n | input | 1 | Read strobe (mode 0) or data strobe (mode 1), active low |
| wr_rw_n | input | 1 | Write strobe (mode 0) or read/not-write line (mode 1) |
| data_in | input | 8 | Byte lane from the host |
| data_out | output | 8 | Byte lane to the host |
| data_oe | output | 1 | Enable for the byte-lane tri-state driver |

## Verification
A fault in the synchroniser or edge-detect state shows up at the ports as a write that is missing, duplicated or lands with the wrong byte. Because every register is swept and read back, the fault is caught on the very next read of the affected address. A wrong latched address moves a value to the neighbouring location, which becomes visible on the first multiplexed read after the faulty write. An output enable that follows the wrong qualifier shows up within three clocks as `data_oe` high while `cs_n` is high or during a write strobe.

// File: rtl/hbs_pkg.sv
package hbs_pkg;

    // Synchronised view of the host control lines.
    typedef struct packed {
        logic cs_n;     // chip select, active low
        logic strb_a;   // read strobe / data strobe
        logic strb_b;   // write strobe / read-not-write
        logic ale;      // address latch enable
    } hbs_ctrl_t;

    localparam hbs_ctrl_t HBS_CTRL_IDLE = '{cs_n: 1'b1, strb_a: 1'b1, strb_b: 1'b1, ale: 1'b0};

endpackage

// File: rtl/hbs_sync.sv
module hbs_sync
    import hbs_pkg::*;
#(
    parameter int ADDR_W     = 9,
    parameter int DATA_W     = 8,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  hbs_ctrl_t         ctrl_raw,
    input  logic [ADDR_W-1:0] addr_raw,
    input  logic [DATA_W-1:0] data_raw,
    output hbs_ctrl_t         ctrl_now,
    output hbs_ctrl_t         ctrl_prev,
    output logic [ADDR_W-1:0] addr_al,
    output logic [DATA_W-1:0] data_al
);

    localparam int STAGES = SYNC_DEPTH + 1;

    typedef struct packed {
        hbs_ctrl_t [STAGES-1:0]             c;
        logic      [STAGES-1:0][ADDR_W-1:0] a;
        logic      [STAGES-1:0][DATA_W-1:0] d;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.c[0] = ctrl_raw;
        st_d.a[0] = addr_raw;
        st_d.d[0] = data_raw;
        for (int i = 1; i < STAGES; i++) begin
            st_d.c[i] = st_q.c[i-1];
            st_d.a[i] = st_q.a[i-1];
            st_d.d[i] = st_q.d[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) begin
                st_q.c[i] <= HBS_CTRL_IDLE;
                st_q.a[i] <= '0;
                st_q.d[i] <= '0;
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_now  = st_q.c[SYNC_DEPTH-1];
    assign ctrl_prev = st_q.c[SYNC_DEPTH];
    assign addr_al   = st_q.a[SYNC_DEPTH];
    assign data_al   = st_q.d[SYNC_DEPTH];

endmodule

// File: rtl/hbs_decode.sv
module hbs_decode
    import hbs_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_moto,
    input  hbs_ctrl_t         ctrl_now,
    input  hbs_ctrl_t         ctrl_prev,
    input  logic [ADDR_W-1:0] addr_al,
    input  logic [DATA_W-1:0] data_al,
    output logic              wr_en,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              rd_active
);

    typedef struct packed {
        logic [ADDR_W-1:0] latch;
    } dec_st_t;

    dec_st_t st_d, st_q;
    logic    ale_fall;
    logic    rise_a;
    logic    rise_b;

    always_comb begin
        st_d     = st_q;
        ale_fall = ctrl_prev.ale && !ctrl_now.ale;
        rise_a   = !ctrl_prev.strb_a && ctrl_now.strb_a;
        rise_b   = !ctrl_prev.strb_b && ctrl_now.strb_b;

        if (ale_fall) begin
            st_d.latch = addr_al;
        end

        acc_addr = ctrl_now.ale ? addr_al : st_q.latch;
        wr_data  = data_al;

        if (mode_moto) begin
            wr_en     = rise_a && !ctrl_prev.strb_b && !ctrl_prev.cs_n;
            rd_active = !ctrl_now.cs_n && !ctrl_now.strb_a && ctrl_now.strb_b;
        end else begin
            wr_en     = rise_b && !ctrl_prev.cs_n;
            rd_active = !ctrl_now.cs_n && !ctrl_now.strb_a;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.latch <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R3: one strobe edge yields one write pulse
    a_r3_one_write_per_edge: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);

    // R5: a strobe with the direction line high never writes
    a_r5_rw_high_never_writes: assert property (@(posedge clk) disable iff (rst)
        (mode_moto && ctrl_prev.strb_b) |-> !wr_en);

endmodule

// File: rtl/hbs_regfile.sv
module hbs_regfile #(
    parameter int NUM_REGS = 32,
    parameter int ADDR_W   = 9,
    parameter int DATA_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic [DATA_W-1:0]   regs_d [NUM_REGS];
    logic [DATA_W-1:0]   regs_q [NUM_REGS];
    logic [NUM_REGS-1:0] hit;
    logic                rd_in_range;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_hit
        assign hit[g] = we && (waddr == ADDR_W'(g));
    end

    always_comb begin
        for (int i = 0; i < NUM_REGS; i++) begin
            regs_d[i] = hit[i] ? wdata : regs_q[i];
        end
        rd_in_range = {1'b0, raddr} < (ADDR_W+1)'(NUM_REGS);
        rdata       = rd_in_range ? regs_q[raddr[IDX_W-1:0]] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                regs_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NUM_REGS; i++) begin
                regs_q[i] <= regs_d[i];
            end
        end
    end

endmodule

// File: rtl/hostbus_slave.sv
module hostbus_slave
    import hbs_pkg::*;
#(
    parameter int ADDR_W     = 9,
    parameter int DATA_W     = 8,
    parameter int NUM_REGS   = 32,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_moto,
    input  logic              cs_n,
    input  logic              ale,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_strb_n,
    input  logic              wr_rw_n,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe
);

    typedef struct packed {
        logic              oe;
        logic [DATA_W-1:0] data;
    } out_st_t;

    hbs_ctrl_t         ctrl_raw;
    hbs_ctrl_t         ctrl_now;
    hbs_ctrl_t         ctrl_prev;
    logic [ADDR_W-1:0] addr_al;
    logic [DATA_W-1:0] data_al;
    logic              wr_en;
    logic [ADDR_W-1:0] acc_addr;
    logic [DATA_W-1:0] wr_data;
    logic              rd_active;
    logic [DATA_W-1:0] rd_data;
    out_st_t           out_d, out_q;

    assign ctrl_raw = '{cs_n: cs_n, strb_a: rd_strb_n, strb_b: wr_rw_n, ale: ale};

    hbs_sync #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .SYNC_DEPTH (SYNC_DEPTH)
    ) u_sync (
        .clk       (clk),
        .rst       (rst),
        .ctrl_raw  (ctrl_raw),
        .addr_raw  (addr),
        .data_raw  (data_in),
        .ctrl_now  (ctrl_now),
        .ctrl_prev (ctrl_prev),
        .addr_al   (addr_al),
        .data_al   (data_al)
    );

    hbs_decode #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_decode (
        .clk       (clk),
        .rst       (rst),
        .mode_moto (mode_moto),
        .ctrl_now  (ctrl_now),
        .ctrl_prev (ctrl_prev),
        .addr_al   (addr_al),
        .data_al   (data_al),
        .wr_en     (wr_en),
        .acc_addr  (acc_addr),
        .wr_data   (wr_data),
        .rd_active (rd_active)
    );

    hbs_regfile #(
        .NUM_REGS (NUM_REGS),
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W)
    ) u_regfile (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_en),
        .waddr (acc_addr),
        .wdata (wr_data),
        .raddr (acc_addr),
        .rdata (rd_data)
    );

    always_comb begin
        out_d.oe   = rd_active;
        out_d.data = rd_active ? rd_data : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign data_out = out_q.data;
    assign data_oe  = out_q.oe;

    // R1: the lane is released when reset ends
    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !data_oe);

    // R8: the lane is driven only after a synchronised select
    a_r8_oe_needs_select: assert property (@(posedge clk) disable iff (rst)
        data_oe |-> $past(!ctrl_now.cs_n));

    // R10: addresses beyond the file read as zero
    a_r10_oob_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (data_oe && $past({1'b0, acc_addr} >= (ADDR_W+1)'(NUM_REGS))) |-> (data_out == '0));

endmodule

// File: tb/hostbus_slave_bench.sv
module hostbus_slave_bench;

    localparam int NREG = 32;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_moto = 1'b0;
    logic       cs_n = 1'b1;
    logic       ale = 1'b1;
    logic [8:0] addr = '0;
    logic       rd_strb_n = 1'b1;
    logic       wr_rw_n = 1'b1;
    logic [7:0] data_in = '0;
    logic [7:0] data_out;
    logic       data_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [7:0] ref_mem [NREG];

    always #10 clk = ~clk;

    hostbus_slave u_hostbus_slave (
        .clk       (clk),
        .rst       (rst),
        .mode_moto (mode_moto),
        .cs_n      (cs_n),
        .ale       (ale),
        .addr      (addr),
        .rd_strb_n (rd_strb_n),
        .wr_rw_n   (wr_rw_n),
        .data_in   (data_in),
        .data_out  (data_out),
        .data_oe   (data_oe)
    );

    function automatic logic [7:0] pat(input int a, input int k);
        return 8'((a * 37 + k * 11 + 5) & 255);
    endfunction

    task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic addr_phase(input bit mux, input logic [8:0] a);
        @(negedge clk);
        ale  = 1'b1;
        addr = a;
        if (mux) begin
            repeat (4) @(negedge clk);
            ale = 1'b0;
            repeat (4) @(negedge clk);
            addr = ~a;
        end
    endtask

    task automatic bus_write(input bit moto, input bit mux, input logic [8:0] a,
                             input logic [7:0] d, input bit sel, output logic oe_mid);
        mode_moto = moto;
        addr_phase(mux, a);
        cs_n    = !sel;
        data_in = d;
        if (moto) wr_rw_n = 1'b0;
        @(negedge clk);
        if (moto) rd_strb_n = 1'b0; else wr_rw_n = 1'b0;
        repeat (5) @(negedge clk);
        oe_mid = data_oe;
        if (moto) rd_strb_n = 1'b1; else wr_rw_n = 1'b1;
        repeat (5) @(negedge clk);
        cs_n    = 1'b1;
        wr_rw_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    task automatic bus_read(input bit moto, input bit mux, input logic [8:0] a,
                            input bit sel, output logic [7:0] d, output logic oe);
        mode_moto = moto;
        addr_phase(mux, a);
        cs_n    = !sel;
        wr_rw_n = 1'b1;
        @(negedge clk);
        rd_strb_n = 1'b0;
        repeat (6) @(negedge clk);
        d  = data_out;
        oe = data_oe;
        rd_strb_n = 1'b1;
        repeat (5) @(negedge clk);
        cs_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        logic       oe;
        for (int i = 0; i < NREG; i++) ref_mem[i] = '0;

        repeat (5) @(negedge clk);
        chk("R1 oe during reset", 9'(data_oe), 9'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 oe after reset", 9'(data_oe), 9'd0);

        // R1 R2: every register starts at zero, strobe-pair read
        for (int a = 0; a < NREG; a++) begin
            bus_read(1'b0, 1'b0, 9'(a), 1'b1, rd, oe);
            chk("R2 read oe", 9'(oe), 9'd1);
            chk("R1 reset contents", 9'(rd), 9'd0);
        end

        // R3 R7: strobe-pair writes with direct address
        for (int a = 0; a < NREG; a++) begin
            ref_mem[a] = pat(a, 1);
            bus_write(1'b0, 1'b0, 9'(a), pat(a, 1), 1'b1, oe);
            chk("R8 oe low in write (mode 0)", 9'(oe), 9'd0);
        end
        // R2 R6: read back with latched address
        for (int a = 0; a < NREG; a++) begin
            bus_read(1'b0, 1'b1, 9'(a), 1'b1, rd, oe);
            chk("R6 R3 latched-address readback", 9'(rd), 9'(ref_mem[a]));
        end

        // R5 R6: direction-line writes with latched address
        for (int a = 0; a < NREG; a++) begin
            ref_mem[a] = pat(a, 2);
            bus_write(1'b1, 1'b1, 9'(a), pat(a, 2), 1'b1, oe);
            chk("R8 oe low in write (mode 1)", 9'(oe), 9'd0);
        end
        // R4 R7: direction-line reads with direct address
        for (int a = 0; a < NREG; a++) begin
            bus_read(1'b1, 1'b0, 9'(a), 1'b1, rd, oe);
            chk("R4 read oe", 9'(oe), 9'd1);
            chk("R4 R5 readback", 9'(rd), 9'(ref_mem[a]));
        end

        // R5: a read strobe with data on the lane does not write
        data_in = 8'h5A;
        bus_read(1'b1, 1'b0, 9'd3, 1'b1, rd, oe);
        bus_read(1'b0, 1'b0, 9'd3, 1'b1, rd, oe);
        chk("R5 read strobe leaves register", 9'(rd), 9'(ref_mem[3]));

        // R8 R9: deselected strobes
        bus_read(1'b0, 1'b0, 9'd4, 1'b0, rd, oe);
        chk("R8 oe low with cs_n high (mode 0)", 9'(oe), 9'd0);
        bus_read(1'b1, 1'b0, 9'd4, 1'b0, rd, oe);
        chk("R8 oe low with cs_n high (mode 1)", 9'(oe), 9'd0);
        bus_write(1'b0, 1'b0, 9'd4, 8'h00, 1'b0, oe);
        bus_write(1'b1, 1'b1, 9'd6, 8'h00, 1'b0, oe);
        bus_read(1'b0, 1'b0, 9'd4, 1'b1, rd, oe);
        chk("R9 deselected write ignored (mode 0)", 9'(rd), 9'(ref_mem[4]));
        bus_read(1'b0, 1'b0, 9'd6, 1'b1, rd, oe);
        chk("R9 deselected write ignored (mode 1)", 9'(rd), 9'(ref_mem[6]));

        // R3: back-to-back writes to one address keep the last
        bus_write(1'b0, 1'b0, 9'd7, 8'hA1, 1'b1, oe);
        bus_write(1'b0, 1'b0, 9'd7, 8'h3C, 1'b1, oe);
        ref_mem[7] = 8'h3C;
        bus_read(1'b1, 1'b1, 9'd7, 1'b1, rd, oe);
        chk("R3 last write wins", 9'(rd), 9'h3C);

        // R10: out-of-range address (421 aliases 5 in the low bits)
        bus_write(1'b0, 1'b0, 9'd421, 8'h77, 1'b1, oe);
        bus_write(1'b1, 1'b1, 9'd500, 8'h66, 1'b1, oe);
        bus_read(1'b0, 1'b0, 9'd421, 1'b1, rd, oe);
        chk("R10 oob read oe", 9'(oe), 9'd1);
        chk("R10 oob read zero", 9'(rd), 9'd0);
        bus_read(1'b1, 1'b1, 9'd500, 1'b1, rd, oe);
        chk("R10 oob read zero (mode 1)", 9'(rd), 9'd0);
        for (int a = 0; a < NREG; a++) begin
            bus_read(1'b0, 1'b0, 9'(a), 1'b1, rd, oe);
            chk("R10 oob write dropped", 9'(rd), 9'(ref_mem[a]));
        end

        // R1: reset in mid-run clears contents
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int a = 0; a < NREG; a += 5) begin
            bus_read(1'b1, 1'b0, 9'(a), 1'b1, rd, oe);
            chk("R1 cleared by reset", 9'(rd), 9'd0);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule